// File: doc/BRIEF.md
# Two-Subphase Address Parity Unit

This block produces and verifies the two parity lines that accompany the address phase of a shared multi-agent processor bus. Each phase carries a 35-bit address field (address bits 37 down to 3) and a 5-bit request code, and it spans two subphases. The address lines carry the physical address in the first subphase and transaction-type information in the second subphase. Every address, request and parity line is active low. Parity is defined on the electrical levels: a parity line is high when an even number of the lines it covers are low.

The two parity lines do not cover the same groups in both subphases. In subphase 1, parity line 0 covers the upper address group (bits 37..24), and parity line 1 covers the lower address group (bits 23..3) together with the request code. In subphase 2 the assignment is swapped.

The transmit side is purely combinational. The initiator supplies the lines it is about to drive and a subphase select, and it receives the two parity lines to drive alongside them. The receive side watches the address strobe. The first cycle after the strobe is sampled low is treated as subphase 1 and the next cycle as subphase 2. In each of those cycles the receive side recomputes parity on the captured lines and raises a registered one-cycle error pulse for each mismatched parity line, tagged with the subphase in which the mismatch occurred.

Top module: `addr_par_unit`

## Requirements
- R1: A generated parity line is high when an even number of its covered lines are low. With every covered line high, both `tx_ap_n` bits are 1 in either subphase.
- R2: With `tx_sp2`=0, `tx_ap_n[0]` covers `tx_addr_n[34:21]` (address bits 37..24). `tx_ap_n[1]` covers `tx_addr_n[20:0]` (address bits 23..3) and `tx_req_n[4:0]`.
- R3: With `tx_sp2`=1, the coverage is swapped. `tx_ap_n[1]` covers `tx_addr_n[34:21]`, and `tx_ap_n[0]` covers `tx_addr_n[20:0]` and `tx_req_n`.
- R4: While no address phase is in progress, `par_err` stays 2'b00 and `par_err_sp2` stays 0, whatever the receive lines carry.
- R5: When `rx_strobe_n` is sampled low in idle, the next cycle is subphase 1. Its lines are checked with the R2 mapping. On a mismatch of `rx_ap_n[i]`, `par_err[i]` is 1 during the following cycle and `par_err_sp2` is 0.
- R6: The cycle after subphase 1 is subphase 2. Its lines are checked with the R3 mapping. On a mismatch of `rx_ap_n[i]`, `par_err[i]` is 1 during the following cycle and `par_err_sp2` is 1.
- R7: Each error pulse lasts one cycle. A parity line that matches in a checked cycle produces no pulse in the cycle after it.
- R8: A strobe sampled low during subphase 1 or subphase 2 does not start a new phase. After subphase 2 the receiver returns to idle.
- R9: A synchronous active-high `rst` returns the receiver to idle and clears `par_err` and `par_err_sp2`. This also applies in the middle of a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_sp2 | input | 1 | Transmit subphase select: 0 = subphase 1, 1 = subphase 2 |
| tx_addr_n | input | 35 | Address lines being driven (index 0 = address bit 3), active low |
| tx_req_n | input | 5 | Request code being driven, active low |
| tx_ap_n | output | 2 | Generated parity lines, electrical level |
| rx_strobe_n | input | 1 | Received address strobe, active low |
| rx_addr_n | input | 35 | Captured address lines for the current subphase, active low |
| rx_req_n | input | 5 | Captured request code for the current subphase, active low |
| rx_ap_n | input | 2 | Captured parity lines for the current subphase |
| par_err | output | 2 | One-cycle mismatch pulse per parity line |
| par_err_sp2 | output | 1 | Subphase tag of the pulse: 0 = subphase 1, 1 = subphase 2 |

## Verification
The in-RTL assertions check the following on every cycle:
- the phase sequence from idle through subphase 1 and subphase 2 back to idle;
- that error pulses appear only after a checked subphase and carry the tag of that subphase;
- that an all-high input group yields high parity.

Only the bench scenarios can show the remaining behaviour. This covers the actual coverage groups of each parity line and their swap between subphases, and the exact cycle in which each pulse lands. It also covers whether a strobe held low through a phase is ignored and whether a reset in the middle of a phase suppresses an error.

// File: rtl/addr_par_pkg.sv
package addr_par_pkg;
    localparam int ADDR_MSB  = 37;
    localparam int ADDR_LSB  = 3;
    localparam int ADDR_W    = ADDR_MSB - ADDR_LSB + 1;
    localparam int HI_SPLIT  = 24;
    localparam int HI_W      = ADDR_MSB - HI_SPLIT + 1;
    localparam int REQ_W     = 5;
    localparam int NPAR      = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SP1  = 2'd1,
        PH_SP2  = 2'd2
    } phase_e;
endpackage

// File: rtl/ap_par_calc.sv
module ap_par_calc #(
    parameter int A_W   = addr_par_pkg::ADDR_W,
    parameter int HI_W  = addr_par_pkg::HI_W,
    parameter int REQ_W = addr_par_pkg::REQ_W
) (
    input  logic [A_W-1:0]   a_n,
    input  logic [REQ_W-1:0] req_n,
    input  logic             sp2,
    output logic [1:0]       ap_n
);
    localparam int LO_W = A_W - HI_W;

    logic [HI_W-1:0]       grp_hi;
    logic [LO_W+REQ_W-1:0] grp_lo;
    logic                  line_hi;
    logic                  line_lo;

    always_comb begin
        grp_hi  = a_n[A_W-1 -: HI_W];
        grp_lo  = {a_n[LO_W-1:0], req_n};
        // odd count of low lines drives the parity line low
        line_hi = ~(^(~grp_hi));
        line_lo = ~(^(~grp_lo));
        if (sp2) begin
            ap_n = {line_hi, line_lo};
        end else begin
            ap_n = {line_lo, line_hi};
        end
    end

    // R1: all covered lines high gives high parity lines
    always_comb begin
        if (!$isunknown({a_n, req_n}) && (&a_n) && (&req_n)) begin
            a_r1_all_high: assert (ap_n == 2'b11)
                else $error("all-high inputs must yield high parity");
        end
    end
endmodule

// File: rtl/ap_phase_fsm.sv
module ap_phase_fsm
    import addr_par_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe_n,
    output phase_e phase
);
    typedef struct packed {
        phase_e ph;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: if (!strobe_n) st_d.ph = PH_SP1;
            PH_SP1:  st_d.ph = PH_SP2;
            PH_SP2:  st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;

    a_r8_sp1_to_sp2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SP1) |=> (phase == PH_SP2));
    a_r8_sp2_to_idle: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SP2) |=> (phase == PH_IDLE));
    a_r5_start_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !strobe_n) |=> (phase == PH_SP1));
endmodule

// File: rtl/ap_err_gen.sv
module ap_err_gen
    import addr_par_pkg::*;
#(
    parameter int NP = addr_par_pkg::NPAR
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic [NP-1:0] exp_ap_n,
    input  logic [NP-1:0] rx_ap_n,
    output logic [NP-1:0] err,
    output logic          err_sp2
);
    typedef struct packed {
        logic [NP-1:0] err;
        logic          sp2;
    } err_t;

    err_t e_d, e_q;
    logic active;

    always_comb begin
        active = (phase == PH_SP1) || (phase == PH_SP2);
        e_d    = '0;
        for (int i = 0; i < NP; i++) begin
            e_d.err[i] = active && (exp_ap_n[i] != rx_ap_n[i]);
        end
        e_d.sp2 = (phase == PH_SP2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign err     = e_q.err;
    assign err_sp2 = e_q.sp2;

    a_r4_idle_no_err: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> (err == '0));
    a_r5_sp1_tag: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SP1) |=> !err_sp2);
    a_r6_sp2_tag: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SP2) |=> err_sp2);
    a_r7_match_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (exp_ap_n == rx_ap_n) |=> (err == '0));
endmodule

// File: rtl/addr_par_unit.sv
module addr_par_unit
    import addr_par_pkg::*;
#(
    parameter int A_W   = addr_par_pkg::ADDR_W,
    parameter int HI_W  = addr_par_pkg::HI_W,
    parameter int REQ_W = addr_par_pkg::REQ_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_sp2,
    input  logic [A_W-1:0]   tx_addr_n,
    input  logic [REQ_W-1:0] tx_req_n,
    output logic [1:0]       tx_ap_n,
    input  logic             rx_strobe_n,
    input  logic [A_W-1:0]   rx_addr_n,
    input  logic [REQ_W-1:0] rx_req_n,
    input  logic [1:0]       rx_ap_n,
    output logic [1:0]       par_err,
    output logic             par_err_sp2
);
    phase_e     phase;
    logic [1:0] rx_exp_n;
    logic       rx_sp2;

    assign rx_sp2 = (phase == PH_SP2);

    ap_par_calc #(.A_W(A_W), .HI_W(HI_W), .REQ_W(REQ_W)) tx_calc_i (
        .a_n   (tx_addr_n),
        .req_n (tx_req_n),
        .sp2   (tx_sp2),
        .ap_n  (tx_ap_n)
    );

    ap_phase_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (rx_strobe_n),
        .phase    (phase)
    );

    ap_par_calc #(.A_W(A_W), .HI_W(HI_W), .REQ_W(REQ_W)) rx_calc_i (
        .a_n   (rx_addr_n),
        .req_n (rx_req_n),
        .sp2   (rx_sp2),
        .ap_n  (rx_exp_n)
    );

    ap_err_gen #(.NP(2)) err_i (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .exp_ap_n (rx_exp_n),
        .rx_ap_n  (rx_ap_n),
        .err      (par_err),
        .err_sp2  (par_err_sp2)
    );
endmodule

// File: tb/addr_par_unit_tb_top.sv
module addr_par_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        tx_sp2;
    logic [34:0] tx_addr_n;
    logic [4:0]  tx_req_n;
    logic [1:0]  tx_ap_n;
    logic        rx_strobe_n;
    logic [34:0] rx_addr_n;
    logic [4:0]  rx_req_n;
    logic [1:0]  rx_ap_n;
    logic [1:0]  par_err;
    logic        par_err_sp2;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    addr_par_unit dut_i (
        .clk(clk), .rst(rst), .tx_sp2(tx_sp2), .tx_addr_n(tx_addr_n),
        .tx_req_n(tx_req_n), .tx_ap_n(tx_ap_n), .rx_strobe_n(rx_strobe_n),
        .rx_addr_n(rx_addr_n), .rx_req_n(rx_req_n), .rx_ap_n(rx_ap_n),
        .par_err(par_err), .par_err_sp2(par_err_sp2)
    );

    // model: line high when count of low covered lines is even
    function automatic logic [1:0] model_ap(input logic [34:0] a,
                                            input logic [4:0] r,
                                            input logic sp2);
        int zh = 0;
        int zl = 0;
        logic lh, ll;
        for (int i = 21; i < 35; i++) if (!a[i]) zh++;
        for (int i = 0; i < 21; i++) if (!a[i]) zl++;
        for (int i = 0; i < 5; i++) if (!r[i]) zl++;
        lh = (zh % 2 == 0);
        ll = (zl % 2 == 0);
        return sp2 ? {lh, ll} : {ll, lh};
    endfunction

    task automatic check(input string req, input logic [3:0] act,
                         input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_lines();
        rx_strobe_n = 1'b1;
        rx_addr_n   = '1;
        rx_req_n    = '1;
        rx_ap_n     = 2'b11;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_lines();
        tx_sp2 = 1'b0; tx_addr_n = '1; tx_req_n = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset err", {1'b0, par_err_sp2, par_err}, 4'h0);
    endtask

    task automatic t_gen_all_high();
        tx_addr_n = '1; tx_req_n = '1;
        tx_sp2 = 1'b0; #1;
        check("R1 all high sp1", {2'b0, tx_ap_n}, 4'h3);
        tx_sp2 = 1'b1; #1;
        check("R1 all high sp2", {2'b0, tx_ap_n}, 4'h3);
    endtask

    task automatic t_gen_patterns();
        logic [34:0] pa [4];
        logic [4:0]  pr [4];
        pa[0] = ~(35'd1 << 34); pr[0] = '1;
        pa[1] = ~35'd1;         pr[1] = '1;
        pa[2] = '1;             pr[2] = 5'b11110;
        pa[3] = 35'h5A5_3C3C_F;  pr[3] = 5'b01011;
        // single low in upper group: sp1 -> line0 low, sp2 -> line1 low
        tx_addr_n = pa[0]; tx_req_n = pr[0]; tx_sp2 = 1'b0; #1;
        check("R2 upper low sp1", {2'b0, tx_ap_n}, 4'h2);
        tx_sp2 = 1'b1; #1;
        check("R3 upper low sp2", {2'b0, tx_ap_n}, 4'h1);
        for (int k = 1; k < 4; k++) begin
            tx_addr_n = pa[k]; tx_req_n = pr[k];
            tx_sp2 = 1'b0; #1;
            check("R2 pattern sp1", {2'b0, tx_ap_n}, {2'b0, model_ap(pa[k], pr[k], 1'b0)});
            tx_sp2 = 1'b1; #1;
            check("R3 pattern sp2", {2'b0, tx_ap_n}, {2'b0, model_ap(pa[k], pr[k], 1'b1)});
        end
    endtask

    // runs one phase; flip masks corrupt the parity of each subphase
    task automatic run_phase(input logic [34:0] a1, input logic [4:0] r1,
                             input logic [1:0] f1, input logic [34:0] a2,
                             input logic [4:0] r2, input logic [1:0] f2,
                             input logic hold_strobe, input string tag);
        rx_strobe_n = 1'b0;
        @(negedge clk);
        rx_strobe_n = hold_strobe ? 1'b0 : 1'b1;
        rx_addr_n = a1; rx_req_n = r1;
        rx_ap_n = model_ap(a1, r1, 1'b0) ^ f1;
        @(negedge clk);
        check({tag, " sp1 result"}, {1'b0, par_err_sp2, par_err},
              {1'b0, (f1 != 0) ? 1'b0 : par_err_sp2, f1});
        check({tag, " sp1 tag"}, {3'b0, (f1 != 0) ? par_err_sp2 : 1'b0}, 4'h0);
        rx_addr_n = a2; rx_req_n = r2;
        rx_ap_n = model_ap(a2, r2, 1'b1) ^ f2;
        @(negedge clk);
        check({tag, " sp2 result"}, {2'b0, par_err}, {2'b0, f2});
        if (f2 != 0) check({tag, " sp2 tag"}, {3'b0, par_err_sp2}, 4'h1);
        idle_lines();
        rx_ap_n = 2'b00;
    endtask

    task automatic t_rx_clean();
        run_phase(35'h1_2345_6789, 5'b10101, 2'b00, 35'h7_0F0F_0F0F, 5'b00110, 2'b00, 1'b0, "R5 R6 clean");
        @(negedge clk);
        check("R4 after clean", {2'b0, par_err}, 4'h0);
        idle_lines();
    endtask

    task automatic t_rx_err_sp1();
        run_phase(35'h3_AAAA_5555, 5'b11000, 2'b01, 35'h0_1234_FFFF, 5'b11111, 2'b00, 1'b0, "R5 err line0");
        @(negedge clk);
        check("R7 pulse ends", {2'b0, par_err}, 4'h0);
        idle_lines();
    endtask

    task automatic t_rx_err_sp2();
        run_phase(35'h2_0000_0001, 5'b00001, 2'b00, 35'h6_DEAD_BEEF, 5'b10010, 2'b10, 1'b0, "R6 err line1");
        @(negedge clk);
        check("R7 pulse ends sp2", {2'b0, par_err}, 4'h0);
        idle_lines();
        run_phase(35'h4_4444_4444, 5'b01110, 2'b10, 35'h1_1111_1111, 5'b01111, 2'b01, 1'b0, "R5 R6 both");
        idle_lines();
        @(negedge clk);
    endtask

    task automatic t_idle();
        rx_strobe_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            rx_addr_n = 35'h0_0F00_00F0 ^ 35'(k);
            rx_ap_n = ~model_ap(rx_addr_n, rx_req_n, 1'b0);
            @(negedge clk);
            check("R4 idle no err", {1'b0, par_err_sp2, par_err}, 4'h0);
        end
        idle_lines();
    endtask

    task automatic t_strobe_ignored();
        run_phase(35'h0_0000_FFFF, 5'b11100, 2'b00, 35'h7_FFFF_0000, 5'b00011, 2'b00, 1'b1, "R8 held");
        // strobe was low through sp2 and must not restart; bad parity now
        rx_strobe_n = 1'b1;
        rx_ap_n = ~model_ap(rx_addr_n, rx_req_n, 1'b0);
        @(negedge clk);
        check("R8 no restart", {2'b0, par_err}, 4'h0);
        @(negedge clk);
        check("R8 no restart 2", {2'b0, par_err}, 4'h0);
        idle_lines();
    endtask

    task automatic t_reset_midphase();
        rx_strobe_n = 1'b0;
        @(negedge clk);
        rx_strobe_n = 1'b1;
        rst = 1'b1;
        rx_ap_n = ~model_ap(rx_addr_n, rx_req_n, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        check("R9 midphase err", {1'b0, par_err_sp2, par_err}, 4'h0);
        rx_ap_n = ~model_ap(rx_addr_n, rx_req_n, 1'b1);
        @(negedge clk);
        check("R9 back to idle", {2'b0, par_err}, 4'h0);
        idle_lines();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_gen_all_high();
        t_gen_patterns();
        t_idle();
        t_rx_clean();
        t_rx_err_sp1();
        t_rx_err_sp2();
        t_strobe_ignored();
        t_reset_midphase();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule